// File: doc/BRIEF.md
# Microcontroller Mailbox and Interrupt Register Unit

This unit sits on a byte-wide microcontroller bus. It holds three one-byte command mailboxes and a three-flag interrupt block. The downstream mailbox carries commands from the microcontroller to the link. The start mailbox holds a start command. The upstream mailbox carries commands from the link to the microcontroller. The link side can load the upstream mailbox, which raises a "command waiting" flag. It can also empty the downstream mailbox, which raises a "command taken" flag. A one-cycle bus-reset pulse raises a third flag.

The microcontroller reads the raw flags from a status register and clears them by writing ones. It masks them through an enable register. It can force the two command flags, but not the bus-reset flag, through a write-only force register. A single registered interrupt line is the OR of the flags that are both set and enabled. Read data is registered, so it appears one cycle after the address is presented.

Top module: `mbx_irq_regs`

## Requirements
- R1: After a synchronous reset, all three mailboxes, all flags and all enables are 0 and `irq` is low.
- R2: The mailboxes sit at address 0 (downstream), 1 (start) and 2 (upstream). A bus write stores all 8 bits, and a read returns them.
- R3: The flag bits are command-taken at bit 0, bus-reset at bit 1 and command-waiting at bit 2. The status register is at address 3, the enable register at 4 and the force register at 5. Reads of addresses 5, 6 and 7 return 0. Bits 7:3 of the status and enable registers read 0 and ignore writes.
- R4: A read of the status register returns the raw flags, whatever the enable mask holds.
- R5: `irq` goes high one cycle after some flag is both set and enabled. It goes low one cycle after no such flag remains.
- R6: Writing a 1 to a status bit clears that flag. Writing a 0 leaves it unchanged.
- R7: Writing a 1 to bit 0 or bit 2 of the force register sets that flag, and a forced command-waiting flag drives `irq` like a hardware one. Bit 1 of the force register and any 0 bits have no effect.
- R8: `lnk_up_we` loads `lnk_up_data` into the upstream mailbox and sets command-waiting. `lnk_down_clr` zeroes the downstream mailbox and sets command-taken. `lnk_bus_rst` sets bus-reset.
- R9: If a hardware event and a status-register clear hit the same flag in the same cycle, the flag ends up set.
- R10: If a link-side update and a bus write hit the same mailbox in the same cycle, the link-side value is stored.
- R11: `bus_rdata` shows the register state at the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lnk_up_we | input | 1 | Link loads the upstream mailbox |
| lnk_up_data | input | 8 | Command byte for the upstream mailbox |
| lnk_down_clr | input | 1 | Link empties the downstream mailbox |
| lnk_bus_rst | input | 1 | Bus-reset event pulse |
| down_cmd | output | 8 | Downstream mailbox contents |
| start_cmd | output | 8 | Start mailbox contents |
| irq | output | 1 | Level interrupt to the microcontroller |

## Verification
Two pairs of functions can collide in one cycle. In the first, a hardware event arrives while the microcontroller clears the same flag. In the second, the link updates a mailbox while the microcontroller writes it. The bench drives both sides of each pair on the same clock edge: a bus-reset pulse together with a write-ones to the status register, and an upstream load together with a bus write to address 2. It also drives a downstream clear together with a bus write to address 0. It then judges the result by reading the registers back: the event flag must stay set while the other flags clear, and the mailbox must hold the link-side value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;

  localparam logic [2:0] A_DOWN  = 3'd0;
  localparam logic [2:0] A_START = 3'd1;
  localparam logic [2:0] A_UP    = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_EN    = 3'd4;
  localparam logic [2:0] A_FORCE = 3'd5;

  localparam int F_TAKEN = 0;
  localparam int F_BRST  = 1;
  localparam int F_WAIT  = 2;

  localparam int NMBOX = 3;
  localparam int MB_DOWN  = 0;
  localparam int MB_START = 1;
  localparam int MB_UP    = 2;

  // software may force only the two command flags
  localparam logic [NFLAG-1:0] FORCE_OK = 3'b101;
endpackage

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              lnk_we,
  input  logic [DATA_W-1:0] lnk_wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (lnk_we) q <= lnk_wdata;   // link side has priority
    else if (cpu_we) q <= cpu_wdata;
  end

  a_r10_link_wins: assert property (@(posedge clk) disable iff (rst)
    lnk_we |=> q == $past(lnk_wdata));
  a_r2_cpu_store: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && !lnk_we) |=> q == $past(cpu_wdata));
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int               NFLAG    = 3,
  parameter logic [NFLAG-1:0] FORCE_OK = 3'b101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [NFLAG-1:0] en_wd,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_wd,
  input  logic             set_we,
  input  logic [NFLAG-1:0] set_wd,
  input  logic [NFLAG-1:0] hw_evt,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] en_q,
  output logic             irq_o
);
  logic [NFLAG-1:0] clr_m, set_m, flag_d;

  always_comb begin
    clr_m  = clr_we ? clr_wd : '0;
    set_m  = set_we ? (set_wd & FORCE_OK) : '0;
    flag_d = (flag_q & ~clr_m) | set_m | hw_evt;  // set beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (en_we) en_q <= en_wd;
      irq_o  <= |(flag_q & en_q);
    end
  end

  a_r5_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & en_q)) |=> irq_o);
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & en_q)) |=> !irq_o);

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    a_r9_evt_wins: assert property (@(posedge clk) disable iff (rst)
      hw_evt[i] |=> flag_q[i]);
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_wd[i] && !hw_evt[i] && !(set_we && set_wd[i])) |=> !flag_q[i]);
    if (!FORCE_OK[i]) begin : g_nf
      a_r7_no_force: assert property (@(posedge clk) disable iff (rst)
        (set_we && !hw_evt[i] && !flag_q[i]) |=> !flag_q[i]);
    end
  end
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NFLAG  = 3,
  parameter int NMBOX  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] mbox [NMBOX],
  input  logic [NFLAG-1:0]  flag_q,
  input  logic [NFLAG-1:0]  en_q,
  output logic [DATA_W-1:0] rdata
);
  import mbx_pkg::*;
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (int'(addr) < NMBOX)            sel = mbox[int'(addr)];
    else if (addr == ADDR_W'(A_STAT))  sel = DATA_W'(flag_q);
    else if (addr == ADDR_W'(A_EN))    sel = DATA_W'(en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_STAT) || addr == ADDR_W'(A_EN)) |=> rdata[DATA_W-1:NFLAG] == '0);
endmodule

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
  import mbx_pkg::*;
#(
  parameter int DW = mbx_pkg::DATA_W,
  parameter int AW = mbx_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          lnk_up_we,
  input  logic [DW-1:0] lnk_up_data,
  input  logic          lnk_down_clr,
  input  logic          lnk_bus_rst,
  output logic [DW-1:0] down_cmd,
  output logic [DW-1:0] start_cmd,
  output logic          irq
);
  logic [DW-1:0]    mbox_q [NMBOX];
  logic [NMBOX-1:0] l_we;
  logic [DW-1:0]    l_wd  [NMBOX];
  logic [NFLAG-1:0] flag_q, en_q, hw_evt;

  always_comb begin
    l_we            = '0;
    l_we[MB_UP]     = lnk_up_we;
    l_we[MB_DOWN]   = lnk_down_clr;
    for (int k = 0; k < NMBOX; k++) l_wd[k] = '0;
    l_wd[MB_UP]     = lnk_up_data;
    hw_evt          = '0;
    hw_evt[F_WAIT]  = lnk_up_we;
    hw_evt[F_TAKEN] = lnk_down_clr;
    hw_evt[F_BRST]  = lnk_bus_rst;
  end

  for (genvar m = 0; m < NMBOX; m++) begin : g_mb
    mbx_mailbox #(.DATA_W(DW)) u_mb (
      .clk(clk), .rst(rst),
      .cpu_we(bus_wr && bus_addr == AW'(m)), .cpu_wdata(bus_wdata),
      .lnk_we(l_we[m]), .lnk_wdata(l_wd[m]), .q(mbox_q[m]));
  end

  mbx_irq_flags #(.NFLAG(NFLAG), .FORCE_OK(FORCE_OK)) u_flags (
    .clk(clk), .rst(rst),
    .en_we(bus_wr && bus_addr == AW'(A_EN)),     .en_wd(bus_wdata[NFLAG-1:0]),
    .clr_we(bus_wr && bus_addr == AW'(A_STAT)),  .clr_wd(bus_wdata[NFLAG-1:0]),
    .set_we(bus_wr && bus_addr == AW'(A_FORCE)), .set_wd(bus_wdata[NFLAG-1:0]),
    .hw_evt(hw_evt), .flag_q(flag_q), .en_q(en_q), .irq_o(irq));

  mbx_rd_mux #(.DATA_W(DW), .ADDR_W(AW), .NFLAG(NFLAG), .NMBOX(NMBOX)) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr), .mbox(mbox_q),
    .flag_q(flag_q), .en_q(en_q), .rdata(bus_rdata));

  assign down_cmd  = mbox_q[MB_DOWN];
  assign start_cmd = mbox_q[MB_START];

  a_r8_down_clear: assert property (@(posedge clk) disable iff (rst)
    lnk_down_clr |=> (down_cmd == '0 && flag_q[F_TAKEN]));
  a_r8_up_flag: assert property (@(posedge clk) disable iff (rst)
    lnk_up_we |=> flag_q[F_WAIT]);
endmodule

// File: tb/tb_mbx_irq_regs.sv
module tb_mbx_irq_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lnk_up_we = 1'b0;
  logic [7:0] lnk_up_data = '0;
  logic       lnk_down_clr = 1'b0;
  logic       lnk_bus_rst = 1'b0;
  logic [7:0] down_cmd, start_cmd;
  logic       irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_irq_regs dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 reg", v, 8'h00); end
  endtask

  task automatic t_mailbox;
    logic [7:0] v;
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'hF0);
    rd(3'd0, v); chk("R2 down", v, 8'hA5);
    rd(3'd1, v); chk("R2 start", v, 8'h3C);
    rd(3'd2, v); chk("R2 up", v, 8'hF0);
    chk("R2 down port", down_cmd, 8'hA5);
    chk("R2 start port", start_cmd, 8'h3C);
    // R11: read data is one cycle behind the address
    @(negedge clk); bus_addr = 3'd1;
    chk("R11 before edge", bus_rdata, 8'hF0);
    @(negedge clk); chk("R11 after edge", bus_rdata, 8'h3C);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R3 en rsvd", v, 8'h07);
    wr(3'd4, 8'h00);
    rd(3'd5, v); chk("R3 force reads 0", v, 8'h00);
    rd(3'd6, v); chk("R3 addr6", v, 8'h00);
    rd(3'd7, v); chk("R3 addr7", v, 8'h00);
  endtask

  task automatic t_events;
    logic [7:0] v;
    @(negedge clk); lnk_bus_rst = 1'b1;
    @(negedge clk); lnk_bus_rst = 1'b0;
    rd(3'd3, v); chk("R8 bus reset flag", v, 8'h02);
    @(negedge clk); lnk_up_we = 1'b1; lnk_up_data = 8'h6E;
    @(negedge clk); lnk_up_we = 1'b0;
    rd(3'd2, v); chk("R8 up load", v, 8'h6E);
    @(negedge clk); lnk_down_clr = 1'b1;
    @(negedge clk); lnk_down_clr = 1'b0;
    chk("R8 down cleared", down_cmd, 8'h00);
    rd(3'd3, v); chk("R8 flags", v, 8'h07);
    // R4: raw read with enables off
    chk("R4 irq masked", {7'd0, irq}, 8'h00);
    rd(3'd3, v); chk("R4 raw status", v, 8'h07);
  endtask

  task automatic t_irq_w1c;
    logic [7:0] v;
    wr(3'd4, 8'h02);
    @(negedge clk); chk("R5 irq on", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'hF8);            // zeros in low bits: no effect
    rd(3'd3, v); chk("R6 zero write", v, 8'h07);
    wr(3'd3, 8'h02);
    rd(3'd3, v); chk("R6 w1c", v, 8'h05);
    chk("R5 irq off", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h05);
    rd(3'd3, v); chk("R6 clear all", v, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_force;
    logic [7:0] v;
    wr(3'd5, 8'h02);
    rd(3'd3, v); chk("R7 bit1 ignored", v, 8'h00);
    wr(3'd4, 8'h04);
    wr(3'd5, 8'h04);
    @(negedge clk); chk("R7 forced irq", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd3, v); chk("R7 force bits", v, 8'h05);
    wr(3'd5, 8'h00);
    rd(3'd3, v); chk("R7 zero no effect", v, 8'h05);
    wr(3'd3, 8'h07); wr(3'd4, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(3'd5, 8'h05);
    @(negedge clk); lnk_bus_rst = 1'b1;
    @(negedge clk); lnk_bus_rst = 1'b0;     // all three set
    @(negedge clk); bus_addr = 3'd3; bus_wdata = 8'h07; bus_wr = 1'b1; lnk_bus_rst = 1'b1;
    @(negedge clk); bus_wr = 1'b0; lnk_bus_rst = 1'b0;
    rd(3'd3, v); chk("R9 event beats clear", v, 8'h02);
    @(negedge clk); bus_addr = 3'd2; bus_wdata = 8'h11; bus_wr = 1'b1;
    lnk_up_we = 1'b1; lnk_up_data = 8'h99;
    @(negedge clk); bus_wr = 1'b0; lnk_up_we = 1'b0;
    rd(3'd2, v); chk("R10 up link wins", v, 8'h99);
    wr(3'd0, 8'h42);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h55; bus_wr = 1'b1; lnk_down_clr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; lnk_down_clr = 1'b0;
    rd(3'd0, v); chk("R10 down link wins", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset(); t_mailbox(); t_map(); t_events();
    t_irq_w1c(); t_force(); t_collide();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule